// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance and Acknowledge Unit

This block sits next to a processor's sequencer and decides when an external interrupt is taken. Devices present a 3-bit encoded request level. The level is registered as pending, and the block compares it with the priority mask in the status word only when the sequencer signals that an instruction has completed. When the pending level wins, the block saves the status word, switches it to supervisor state with tracing off, and raises the mask to the accepted level. It then holds an acknowledge cycle open until an external agent ends it.

The agent ends the cycle in one of three ways. A device can place its own vector on the data lines. External logic can request an automatic vector, which the block computes from the level. A bus error marks the interrupt as spurious. The resulting 8-bit vector number is presented for one cycle. Level 7 acts as a non-maskable request: it can pass a mask of 7, but only once for each new rise to that level.

Top module: `irq_ack_unit`

## Requirements
- R1: After reset the status word reads 16'h2700 (supervisor bit 13 set, trace bit 15 clear, mask bits 10:8 = 7). The saved copy is zero, and the acknowledge and vector-valid outputs are low.
- R2: The request input is a level from 0 to 7, where 0 means no request. It is registered once, and the registered value is the pending level used for every decision.
- R3: A pending level can be accepted only in a cycle where the instruction-boundary strobe is high and no acknowledge cycle is open. It is accepted when it is nonzero and greater than the mask.
- R4: A pending level less than or equal to the mask is not accepted. It waits until a status write lowers the mask below it.
- R5: On acceptance the saved copy receives the previous status word. In the new status word bit 13 is set, bit 15 is cleared, bits 10:8 take the accepted level, and all other bits are kept.
- R6: The acknowledge output is high from the cycle after acceptance until the cycle after a terminating input. During that time the level output shows the accepted level.
- R7: A device acknowledge alone ends the cycle with the vector number taken from data bits 7:0.
- R8: An autovector request, with no bus error, ends the cycle with vector number 24 plus the level.
- R9: A bus error ends the cycle with vector number 24 (spurious). Priority among the terminating inputs is bus error, then autovector, then device acknowledge.
- R10: A pending level of 7 is accepted against a mask of 7 only after a fresh rise of the request to 7. Holding the request at 7 does not cause a second acceptance.
- R11: A status write loads the whole status word. If a write and an acceptance fall in the same cycle, the acceptance wins and the write is dropped.
- R12: The vector-valid output is a one-cycle pulse. It comes in the cycle after the terminating input, together with the vector number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lvl_i | input | 3 | Encoded interrupt request level |
| insn_boundary_i | input | 1 | High in cycles where an instruction has completed |
| sr_wr_i | input | 1 | Status word write strobe |
| sr_wdata_i | input | 16 | Status word write data |
| dtack_i | input | 1 | Device supplies the vector on data_i |
| avec_i | input | 1 | Automatic vector request |
| berr_i | input | 1 | Bus error during the acknowledge |
| data_i | input | 8 | Device vector data |
| sr_o | output | 16 | Current status word |
| sr_saved_o | output | 16 | Status word captured at the last acceptance |
| iack_o | output | 1 | Acknowledge cycle open |
| ack_lvl_o | output | 3 | Level shown on the low address bits during acknowledge |
| vec_valid_o | output | 1 | Vector number valid pulse |
| vec_num_o | output | 8 | Vector number |

## Verification
Two functions can fall in the same cycle. One is a software status write. The other is an acceptance that rewrites the same status word. The bench raises the write strobe, carrying a higher mask, in the very cycle the boundary strobe admits a pending level. It then expects the accepted level in the mask and the pre-write word in the saved copy. A second collision puts the bus-error and autovector inputs high together, and the bench expects the spurious vector.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    localparam int LVL_W = 3;
    localparam int VEC_W = 8;
    localparam int SR_W  = 16;

    localparam int SR_T_BIT = 15;
    localparam int SR_S_BIT = 13;
    localparam int SR_M_LSB = 8;

    localparam logic [LVL_W-1:0] LVL_MAX       = {LVL_W{1'b1}};
    localparam logic [VEC_W-1:0] VEC_SPURIOUS  = 8'd24;
    localparam logic [VEC_W-1:0] VEC_AUTO_BASE = 8'd24;
    localparam logic [SR_W-1:0]  SR_RESET      = 16'h2700;

    typedef enum logic {ST_IDLE, ST_ACK} ack_st_e;

    typedef struct packed {
        ack_st_e          st;
        logic [SR_W-1:0]  sr;
        logic [SR_W-1:0]  saved;
        logic [LVL_W-1:0] lvl;
        logic             vv;
        logic [VEC_W-1:0] vec;
    } ack_state_t;
endpackage

// File: rtl/irq_req_sampler.sv
module irq_req_sampler
    import irq_ack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] irq_i,
    input  logic             nmi_take_i,
    output logic [LVL_W-1:0] pend_o,
    output logic             nmi_arm_o
);
    logic [LVL_W-1:0] pend_d, pend_q;
    logic             arm_d, arm_q;

    always_comb begin
        pend_d = irq_i;
        if (irq_i != LVL_MAX)
            arm_d = 1'b0;
        else if (pend_q != LVL_MAX)
            arm_d = 1'b1;
        else if (nmi_take_i)
            arm_d = 1'b0;
        else
            arm_d = arm_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            arm_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            arm_q  <= arm_d;
        end
    end

    assign pend_o    = pend_q;
    assign nmi_arm_o = arm_q;
endmodule

// File: rtl/irq_prio_cmp.sv
module irq_prio_cmp
    import irq_ack_pkg::*;
(
    input  logic [LVL_W-1:0] pend_i,
    input  logic [LVL_W-1:0] mask_i,
    input  logic             nmi_arm_i,
    output logic             win_o,
    output logic             nmi_o
);
    always_comb begin
        nmi_o = (pend_i == LVL_MAX);
        win_o = (pend_i != '0) && ((pend_i > mask_i) || (nmi_o && nmi_arm_i));
    end
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel
    import irq_ack_pkg::*;
(
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             dtack_i,
    input  logic             avec_i,
    input  logic             berr_i,
    input  logic [VEC_W-1:0] data_i,
    output logic             done_o,
    output logic [VEC_W-1:0] vec_o
);
    localparam int PAD_W = VEC_W - LVL_W;

    always_comb begin
        done_o = dtack_i | avec_i | berr_i;
        if (berr_i)
            vec_o = VEC_SPURIOUS;
        else if (avec_i)
            vec_o = VEC_AUTO_BASE + {{PAD_W{1'b0}}, lvl_i};
        else
            vec_o = data_i;
    end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irq_ack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] irq_lvl_i,
    input  logic             insn_boundary_i,
    input  logic             sr_wr_i,
    input  logic [SR_W-1:0]  sr_wdata_i,
    input  logic             dtack_i,
    input  logic             avec_i,
    input  logic             berr_i,
    input  logic [VEC_W-1:0] data_i,
    output logic [SR_W-1:0]  sr_o,
    output logic [SR_W-1:0]  sr_saved_o,
    output logic             iack_o,
    output logic [LVL_W-1:0] ack_lvl_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_num_o
);
    ack_state_t       s_d, s_q;
    logic [LVL_W-1:0] pend;
    logic             nmi_arm, win, is_nmi, accept, done;
    logic [VEC_W-1:0] vec_sel;

    irq_req_sampler u_samp (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_i      (irq_lvl_i),
        .nmi_take_i (accept && is_nmi),
        .pend_o     (pend),
        .nmi_arm_o  (nmi_arm)
    );

    irq_prio_cmp u_cmp (
        .pend_i    (pend),
        .mask_i    (s_q.sr[SR_M_LSB +: LVL_W]),
        .nmi_arm_i (nmi_arm),
        .win_o     (win),
        .nmi_o     (is_nmi)
    );

    irq_vec_sel u_vec (
        .lvl_i   (s_q.lvl),
        .dtack_i (dtack_i),
        .avec_i  (avec_i),
        .berr_i  (berr_i),
        .data_i  (data_i),
        .done_o  (done),
        .vec_o   (vec_sel)
    );

    always_comb begin
        s_d    = s_q;
        s_d.vv = 1'b0;
        accept = (s_q.st == ST_IDLE) && insn_boundary_i && win;
        if (accept) begin
            s_d.saved                     = s_q.sr;
            s_d.sr[SR_T_BIT]              = 1'b0;
            s_d.sr[SR_S_BIT]              = 1'b1;
            s_d.sr[SR_M_LSB +: LVL_W]     = pend;
            s_d.lvl                       = pend;
            s_d.st                        = ST_ACK;
        end else if (sr_wr_i) begin
            s_d.sr = sr_wdata_i;
        end
        if (s_q.st == ST_ACK && done) begin
            s_d.vv  = 1'b1;
            s_d.vec = vec_sel;
            s_d.st  = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.sr    <= SR_RESET;
            s_q.saved <= '0;
            s_q.lvl   <= '0;
            s_q.vv    <= 1'b0;
            s_q.vec   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sr_o        = s_q.sr;
    assign sr_saved_o  = s_q.saved;
    assign iack_o      = (s_q.st == ST_ACK);
    assign ack_lvl_o   = s_q.lvl;
    assign vec_valid_o = s_q.vv;
    assign vec_num_o   = s_q.vec;
endmodule

module irq_ack_chk
    import irq_ack_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             insn_boundary_i,
    input logic             dtack_i,
    input logic             avec_i,
    input logic             berr_i,
    input logic [VEC_W-1:0] data_i,
    input logic [SR_W-1:0]  sr_o,
    input logic [SR_W-1:0]  sr_saved_o,
    input logic             iack_o,
    input logic [LVL_W-1:0] ack_lvl_o,
    input logic             vec_valid_o,
    input logic [VEC_W-1:0] vec_num_o
);
    assert_take_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack_o) |-> $past(insn_boundary_i));

    assert_status_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack_o) |-> (sr_saved_o == $past(sr_o)) && sr_o[SR_S_BIT] && !sr_o[SR_T_BIT]
                          && (sr_o[SR_M_LSB +: LVL_W] == ack_lvl_o));

    assert_ack_level_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iack_o |-> ack_lvl_o != '0);

    assert_device_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iack_o && dtack_i && !avec_i && !berr_i |=> vec_valid_o && (vec_num_o == $past(data_i)));

    assert_auto_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iack_o && avec_i && !berr_i |=> vec_valid_o
            && (vec_num_o == VEC_AUTO_BASE + {5'd0, $past(ack_lvl_o)}));

    assert_spurious_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        iack_o && berr_i |=> vec_valid_o && (vec_num_o == VEC_SPURIOUS));

    assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> $past(iack_o) && !iack_o);
endmodule

bind irq_ack_unit irq_ack_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .insn_boundary_i (insn_boundary_i),
    .dtack_i         (dtack_i),
    .avec_i          (avec_i),
    .berr_i          (berr_i),
    .data_i          (data_i),
    .sr_o            (sr_o),
    .sr_saved_o      (sr_saved_o),
    .iack_o          (iack_o),
    .ack_lvl_o       (ack_lvl_o),
    .vec_valid_o     (vec_valid_o),
    .vec_num_o       (vec_num_o)
);

// File: tb/irq_ack_unit_tb.sv
module irq_ack_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  irq_lvl = '0;
    logic        bnd = 1'b0, sr_wr = 1'b0;
    logic [15:0] sr_wdata = '0;
    logic        dtack = 1'b0, avec = 1'b0, berr = 1'b0;
    logic [7:0]  data = '0;
    logic [15:0] sr, saved;
    logic        iack, vv;
    logic [2:0]  alvl;
    logic [7:0]  vnum;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;
    logic [7:0] exp_q [$];

    always #10 clk = ~clk;

    irq_ack_unit u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lvl_i(irq_lvl), .insn_boundary_i(bnd),
        .sr_wr_i(sr_wr), .sr_wdata_i(sr_wdata), .dtack_i(dtack), .avec_i(avec),
        .berr_i(berr), .data_i(data), .sr_o(sr), .sr_saved_o(saved), .iack_o(iack),
        .ack_lvl_o(alvl), .vec_valid_o(vv), .vec_num_o(vnum)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a vector is produced
    always @(negedge clk) begin
        if (rst_n && vv) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected vector", {24'd0, vnum}, 32'hFFFF_FFFF);
            end else begin
                check("R7/R8/R9 vector", {24'd0, vnum}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic write_sr(input logic [15:0] v);
        @(negedge clk); sr_wr = 1'b1; sr_wdata = v;
        @(negedge clk); sr_wr = 1'b0;
    endtask

    task automatic set_irq(input logic [2:0] l);
        @(negedge clk); irq_lvl = l;
        @(negedge clk);
    endtask

    task automatic boundary();
        @(negedge clk); bnd = 1'b1;
        @(negedge clk); bnd = 1'b0;
    endtask

    // driver: terminates the acknowledge and pushes the expected vector
    task automatic terminate(input logic d, input logic a, input logic b,
                             input logic [7:0] dv, input logic [7:0] expv);
        exp_q.push_back(expv);
        @(negedge clk); dtack = d; avec = a; berr = b; data = dv;
        @(negedge clk); dtack = 1'b0; avec = 1'b0; berr = 1'b0;
        check("R12 valid pulse", {31'd0, vv}, 32'd1);
        check("R6 ack closed", {31'd0, iack}, 32'd0);
        @(negedge clk);
        check("R12 pulse one cycle", {31'd0, vv}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sr reset", {16'd0, sr}, 32'h2700);
        check("R1 saved reset", {16'd0, saved}, 32'h0);
        check("R1 iack reset", {31'd0, iack}, 32'd0);
        check("R1 valid reset", {31'd0, vv}, 32'd0);

        // R4: held off at mask 3, then level 5 taken; R5 trace cleared
        write_sr(16'h8300);
        set_irq(3'd3);
        boundary();
        check("R4 level<=mask held", {31'd0, iack}, 32'd0);
        set_irq(3'd5);
        boundary();
        check("R3 accepted", {31'd0, iack}, 32'd1);
        check("R5 new sr", {16'd0, sr}, 32'h2500);
        check("R5 saved", {16'd0, saved}, 32'h8300);
        check("R6 ack level", {29'd0, alvl}, 32'd5);
        terminate(1'b1, 1'b0, 1'b0, 8'h40, 8'h40);   // R7

        // R4: held request released by lowering the mask
        set_irq(3'd2);
        boundary();
        check("R4 level 2 under mask 5", {31'd0, iack}, 32'd0);
        write_sr(16'h0000);
        check("R2 pending kept", {31'd0, iack}, 32'd0);
        boundary();
        check("R4 taken after mask lowered", {31'd0, iack}, 32'd1);
        terminate(1'b0, 1'b1, 1'b0, 8'h00, 8'd26);   // R8

        // R3: no acceptance without boundary
        write_sr(16'h0000);
        set_irq(3'd4);
        repeat (5) @(negedge clk);
        check("R3 no boundary no take", {31'd0, iack}, 32'd0);
        boundary();
        check("R6 ack level 4", {29'd0, alvl}, 32'd4);
        terminate(1'b1, 1'b1, 1'b1, 8'h77, 8'd24);   // R9 priority

        // R10: level 7 against mask 7
        set_irq(3'd0);
        write_sr(16'h2700);
        set_irq(3'd7);
        boundary();
        check("R10 nmi taken", {31'd0, iack}, 32'd1);
        check("R10 saved", {16'd0, saved}, 32'h2700);
        terminate(1'b0, 1'b1, 1'b0, 8'h00, 8'd31);   // R8
        boundary();
        check("R10 held 7 not retaken", {31'd0, iack}, 32'd0);
        set_irq(3'd0);
        set_irq(3'd7);
        boundary();
        check("R10 new rise retaken", {31'd0, iack}, 32'd1);
        terminate(1'b1, 1'b0, 1'b0, 8'h5A, 8'h5A);
        set_irq(3'd0);

        // R11: status write collides with acceptance
        write_sr(16'h0000);
        set_irq(3'd3);
        @(negedge clk); bnd = 1'b1; sr_wr = 1'b1; sr_wdata = 16'h0700;
        @(negedge clk); bnd = 1'b0; sr_wr = 1'b0;
        check("R11 acceptance wins", {31'd0, iack}, 32'd1);
        check("R11 sr mask=level", {16'd0, sr}, 32'h2300);
        check("R11 saved pre-write", {16'd0, saved}, 32'h0000);
        terminate(1'b1, 1'b0, 1'b0, 8'h99, 8'h99);

        repeat (2) @(negedge clk);
        check("R12 scoreboard drained", exp_q.size(), 32'd0);
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule